// File: doc/BRIEF.md
# DMA Channel Interrupt Status Aggregator

This block gathers completion and error events from a bank of DMA channels into two status registers and drives one interrupt line. Each channel raises single-cycle pulses: one for a finished transfer, one for a bus fault and one for a termination. Every pulse sets a flag that stays set until software clears it through the register write port. The error register also records, for each channel, whether the most recent error was a bus fault or a termination.

Software reaches both registers through three write addresses per register. The first overwrites the register, the second ORs the written ones into it, and the third clears the bits written as ones. A pending-channel encoder names the single most urgent channel, so an interrupt handler can serve channels one at a time without scanning both registers. A termination that lands on a channel whose completion flag is also set is treated as a normal finish, not as a fault.

Top module: `dma_irq_aggregator`

## Requirements
- R1: After a synchronous reset with rst_n low, both registers read zero, irq is low and pend_valid is low.
- R2: A pulse on cmpl_evt[i] sets bit i of the completion register. Bits 16+i of that register are per-channel interrupt enables, and only software writes change them.
- R3: A pulse on bus_err_evt[i] or term_err_evt[i] sets bit i of the error register. Bit 16+i becomes 1 for a bus fault and 0 for a termination only. When both pulses arrive in the same cycle, it becomes 1.
- R4: wr_addr[2] selects the register (0 completion, 1 error). wr_addr[1:0] selects the action: 00 overwrites the register, 01 ORs wr_data into it, 10 clears the bits where wr_data is 1, and 11 has no effect.
- R5: When an event pulse and a software write reach the same bit in the same cycle, the event wins. A flag stays set, and a kind bit takes the value the event gives it.
- R6: irq is high when any completion flag with its enable bit set is high, or when any error flag is high.
- R7: The error of channel i is reportable when its error flag is set and either its kind bit is 1 or its completion flag is clear.
- R8: The encoder reports the highest-numbered channel with a reportable error, with pend_is_err high. If there is none, it reports the highest-numbered channel whose completion flag is set, with pend_is_err low. Enable bits play no part in this choice.
- R9: When no error is reportable and no completion flag is set, pend_valid, pend_is_err and pend_ch are all zero.
- R10: rd_data shows the completion register when rd_sel is 0 and the error register when rd_sel is 1, in the same cycle, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select (bit 2) and write action (bits 1:0) |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read select: 0 completion, 1 error |
| rd_data | output | 32 | Selected register contents |
| cmpl_evt | input | 16 | Per-channel completion pulses |
| bus_err_evt | input | 16 | Per-channel bus-fault pulses |
| term_err_evt | input | 16 | Per-channel termination pulses |
| irq | output | 1 | Combined interrupt |
| pend_valid | output | 1 | Some channel is pending |
| pend_is_err | output | 1 | Pending channel has a reportable error |
| pend_ch | output | 4 | Pending channel number |

## Verification
Hardware events and software writes can reach the same register bit in the same clock cycle. The case to watch is a clear-alias write that lands on a bit while that bit's event pulse arrives. The bench forces this collision directly, and it also comes up again and again under random traffic, where writes and sparse pulses overlap. After every cycle, both registers, the interrupt and the encoder outputs are compared with a bench model in which the event takes precedence over the write.

// File: rtl/dia_pkg.sv
// Shared definitions for the DMA interrupt status aggregator.
// Assumes a 3-bit write address: bit 2 selects the register, bits 1:0 the action.
package dia_pkg;
    typedef enum logic [1:0] {
        WACT_OVERWRITE = 2'b00,
        WACT_SET       = 2'b01,
        WACT_CLEAR     = 2'b10,
        WACT_NONE      = 2'b11
    } wr_action_t;

    localparam logic SEL_CMPL = 1'b0;
    localparam logic SEL_ERR  = 1'b1;
endpackage

// File: rtl/dia_alias_reg.sv
// Status register with overwrite/set/clear write actions plus hardware set and
// clear masks. Hardware masks are applied after the software action, so events
// win over a concurrent write. Assumes hw_set and hw_clr never overlap.
module dia_alias_reg
    import dia_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  wr_action_t       wr_act,
    input  logic [W-1:0]     wr_data,
    input  logic [W-1:0]     hw_set,
    input  logic [W-1:0]     hw_clr,
    output logic [W-1:0]     q
);
    logic [W-1:0] sw_next;

    // Software action applied to the current value.
    always_comb begin
        sw_next = q;
        if (wr_hit) begin
            unique case (wr_act)
                WACT_OVERWRITE: sw_next = wr_data;
                WACT_SET:       sw_next = q | wr_data;
                WACT_CLEAR:     sw_next = q & ~wr_data;
                default:        sw_next = q;
            endcase
        end
    end

    // Register update: hardware events override software.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (sw_next & ~hw_clr) | hw_set;
    end
endmodule

// File: rtl/dia_prio_enc.sv
// Highest-index-first encoder over an N-bit request vector.
// Outputs zero index and valid low when no bit is set.
module dia_prio_enc #(
    parameter int N   = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx
);
    // Scan upward so the last hit, the highest index, wins.
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dma_irq_aggregator.sv
// Collects per-channel completion and error pulses into two status registers,
// drives one interrupt and names the most urgent pending channel.
// Assumes event inputs are synchronous single-cycle pulses.
module dma_irq_aggregator
    import dia_pkg::*;
#(
    parameter int NCH = 16,
    localparam int RW = 2 * NCH,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [RW-1:0] wr_data,
    input  logic          rd_sel,
    output logic [RW-1:0] rd_data,
    input  logic [NCH-1:0] cmpl_evt,
    input  logic [NCH-1:0] bus_err_evt,
    input  logic [NCH-1:0] term_err_evt,
    output logic          irq,
    output logic          pend_valid,
    output logic          pend_is_err,
    output logic [CW-1:0] pend_ch
);
    wr_action_t    act;
    logic [RW-1:0] cmpl_q, err_q;
    logic [RW-1:0] cmpl_hw_set, err_hw_set, err_hw_clr;
    logic [NCH-1:0] cmpl_flags, cmpl_en, err_flags, err_kind, reportable;
    logic          rep_valid, done_valid;
    logic [CW-1:0] rep_ch, done_ch;

    assign act = wr_action_t'(wr_addr[1:0]);

    // Hardware masks from event pulses.
    always_comb begin
        cmpl_hw_set = {{NCH{1'b0}}, cmpl_evt};
        err_hw_set  = {bus_err_evt, bus_err_evt | term_err_evt};
        err_hw_clr  = {term_err_evt & ~bus_err_evt, {NCH{1'b0}}};
    end

    dia_alias_reg #(.W(RW)) u_cmpl_reg (
        .clk(clk), .rst_n(rst_n),
        .wr_hit(wr_en && wr_addr[2] == SEL_CMPL), .wr_act(act), .wr_data(wr_data),
        .hw_set(cmpl_hw_set), .hw_clr({RW{1'b0}}), .q(cmpl_q)
    );

    dia_alias_reg #(.W(RW)) u_err_reg (
        .clk(clk), .rst_n(rst_n),
        .wr_hit(wr_en && wr_addr[2] == SEL_ERR), .wr_act(act), .wr_data(wr_data),
        .hw_set(err_hw_set), .hw_clr(err_hw_clr), .q(err_q)
    );

    // Field split and reportable-error qualification.
    always_comb begin
        cmpl_flags = cmpl_q[NCH-1:0];
        cmpl_en    = cmpl_q[RW-1:NCH];
        err_flags  = err_q[NCH-1:0];
        err_kind   = err_q[RW-1:NCH];
        reportable = err_flags & (err_kind | ~cmpl_flags);
    end

    dia_prio_enc #(.N(NCH)) u_rep_enc  (.req(reportable), .valid(rep_valid),  .idx(rep_ch));
    dia_prio_enc #(.N(NCH)) u_done_enc (.req(cmpl_flags), .valid(done_valid), .idx(done_ch));

    // Errors outrank completions.
    always_comb begin
        pend_valid  = rep_valid | done_valid;
        pend_is_err = rep_valid;
        pend_ch     = rep_valid ? rep_ch : done_ch;
    end

    // Combined interrupt and read mux.
    always_comb begin
        irq     = (|(cmpl_flags & cmpl_en)) | (|err_flags);
        rd_data = (rd_sel == SEL_ERR) ? err_q : cmpl_q;
    end
endmodule

// File: rtl/dia_checker.sv
// Temporal checks for dma_irq_aggregator, attached by bind.
module dia_checker #(
    parameter int NCH = 16,
    localparam int RW = 2 * NCH,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic [2:0]     wr_addr,
    input logic [RW-1:0]  wr_data,
    input logic [NCH-1:0] cmpl_evt,
    input logic [NCH-1:0] bus_err_evt,
    input logic [NCH-1:0] term_err_evt,
    input logic [RW-1:0]  cmpl_q,
    input logic [RW-1:0]  err_q,
    input logic           irq,
    input logic           pend_valid,
    input logic           pend_is_err,
    input logic [CW-1:0]  pend_ch
);
    // R2
    cmpl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cmpl_evt) |=> ((cmpl_q[NCH-1:0] & $past(cmpl_evt)) == $past(cmpl_evt)));

    // R3
    bus_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|bus_err_evt) |=> ((err_q[RW-1:NCH] & $past(bus_err_evt)) == $past(bus_err_evt)));

    // R4
    clear_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'b010 && cmpl_evt == '0) |=> ((cmpl_q & $past(wr_data)) == '0));

    // R6
    err_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q[NCH-1:0] != '0) |-> irq);

    // R7
    rep_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_is_err |-> (err_q[pend_ch] && (err_q[NCH + int'(pend_ch)] || !cmpl_q[pend_ch])));

    // R9
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_valid |-> (cmpl_q[NCH-1:0] == '0 && err_q[NCH-1:0] == '0 && pend_ch == '0));
endmodule

bind dma_irq_aggregator dia_checker #(.NCH(NCH)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmpl_evt(cmpl_evt), .bus_err_evt(bus_err_evt), .term_err_evt(term_err_evt),
    .cmpl_q(cmpl_q), .err_q(err_q), .irq(irq), .pend_valid(pend_valid),
    .pend_is_err(pend_is_err), .pend_ch(pend_ch)
);

// File: tb/dma_irq_aggregator_tb.sv
module dma_irq_aggregator_tb_top;
    localparam int NCH = 16;
    localparam int RW  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [RW-1:0] wr_data = '0;
    logic rd_sel = 1'b0;
    logic [RW-1:0] rd_data;
    logic [NCH-1:0] cmpl_evt = '0, bus_err_evt = '0, term_err_evt = '0;
    logic irq, pend_valid, pend_is_err;
    logic [3:0] pend_ch;

    int tests = 0, fails = 0, cyc = 0;
    logic [RW-1:0] m_c = '0, m_e = '0;

    always #10 clk = ~clk;

    dma_irq_aggregator #(.NCH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .cmpl_evt(cmpl_evt), .bus_err_evt(bus_err_evt),
        .term_err_evt(term_err_evt), .irq(irq), .pend_valid(pend_valid),
        .pend_is_err(pend_is_err), .pend_ch(pend_ch)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog expired: actual %0d cycles expected < 20000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] apply_wr(logic [31:0] q, logic hit, logic [1:0] a, logic [31:0] d);
        if (!hit) return q;
        case (a)
            2'b00: return d;
            2'b01: return q | d;
            2'b10: return q & ~d;
            default: return q;
        endcase
    endfunction

    function automatic logic [5:0] exp_pend(logic [31:0] c, logic [31:0] e);
        // {valid, is_err, ch[3:0]}
        logic [15:0] rep;
        logic [5:0] r;
        rep = e[15:0] & (e[31:16] | ~c[15:0]);
        r = '0;
        if (rep != 0) begin
            for (int i = 0; i < 16; i++) if (rep[i]) r = {2'b11, 4'(i)};
        end else begin
            for (int i = 0; i < 16; i++) if (c[i]) r = {2'b10, 4'(i)};
        end
        return r;
    endfunction

    task automatic check_all();
        logic [5:0] p;
        rd_sel = 1'b0; #1;
        check("R10 completion read", rd_data, m_c);
        rd_sel = 1'b1; #1;
        check("R10 error read", rd_data, m_e);
        check("R6 irq", 32'(irq), 32'((|(m_c[15:0] & m_c[31:16])) | (|m_e[15:0])));
        p = exp_pend(m_c, m_e);
        check("R9 pend_valid", 32'(pend_valid), 32'(p[5]));
        check("R7 pend_is_err", 32'(pend_is_err), 32'(p[4]));
        check("R8 pend_ch", 32'(pend_ch), 32'(p[3:0]));
    endtask

    task automatic step(logic we, logic [2:0] wa, logic [31:0] wd,
                        logic [15:0] ce, logic [15:0] be, logic [15:0] te);
        wr_en = we; wr_addr = wa; wr_data = wd;
        cmpl_evt = ce; bus_err_evt = be; term_err_evt = te;
        @(posedge clk);
        m_c = apply_wr(m_c, we && !wa[2], wa[1:0], wd) | {16'b0, ce};
        m_e = (apply_wr(m_e, we && wa[2], wa[1:0], wd) & ~{te & ~be, 16'b0}) | {be, be | te};
        @(negedge clk);
        wr_en = 1'b0; cmpl_evt = '0; bus_err_evt = '0; term_err_evt = '0;
        check_all();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd_sel = 1'b0; #1;
        check("R1 completion after reset", rd_data, 32'h0);
        rd_sel = 1'b1; #1;
        check("R1 error after reset", rd_data, 32'h0);
        check("R1 irq after reset", 32'(irq), 32'h0);
        check("R1 pend_valid after reset", 32'(pend_valid), 32'h0);

        // R2: completion on ch3 without enable: flag set, irq low
        step(0, 3'b000, 0, 16'h0008, 0, 0);
        check("R2 flag without enable", m_c, 32'h0000_0008);
        check("R2 irq needs enable", 32'(irq), 32'h0);
        // R4: set alias on enables
        step(1, 3'b001, 32'h0008_0000, 0, 0, 0);
        check("R4 set alias", m_c, 32'h0008_0008);
        // R4: code 11 ignored
        step(1, 3'b011, 32'hFFFF_FFFF, 0, 0, 0);
        rd_sel = 1'b0; #1;
        check("R4 code 11 ignored", rd_data, 32'h0008_0008);
        // R5: clear alias collides with new completion on ch3
        step(1, 3'b010, 32'h0000_0008, 16'h0008, 0, 0);
        rd_sel = 1'b0; #1;
        check("R5 event beats clear", rd_data, 32'h0008_0008);
        // R7: termination on ch3 while completed -> not reportable
        step(0, 3'b000, 0, 0, 0, 16'h0008);
        check("R7 term with completion not error", 32'(pend_is_err), 32'h0);
        // R3: bus and term same cycle on ch9 -> kind 1; term-only ch1 -> kind 0
        step(0, 3'b000, 0, 0, 16'h0200, 16'h0202);
        rd_sel = 1'b1; #1;
        check("R3 error kinds", rd_data, 32'h0200_020A);
        // R8: error ch9 beats completion
        check("R8 error priority", {pend_is_err, pend_ch}, {1'b1, 4'd9});
        // R5: term on ch9 collides with set of kind bit -> kind cleared
        step(1, 3'b101, 32'h0200_0000, 0, 0, 16'h0200);
        rd_sel = 1'b1; #1;
        check("R5 event kind wins", 32'(rd_data[25]), 32'h0);
        // R4: overwrite then clear everything
        step(1, 3'b100, 32'h0, 0, 0, 0);
        step(1, 3'b000, 32'h0, 0, 0, 0);
        check("R9 idle outputs", {pend_valid, pend_is_err, pend_ch}, 6'h0);

        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] wd;
            logic [2:0] wa;
            wd = $urandom;
            wa = 3'($urandom);
            step(($urandom % 3) == 0, wa, wd,
                 16'($urandom & $urandom & $urandom),
                 16'($urandom & $urandom & $urandom & $urandom),
                 16'($urandom & $urandom & $urandom));
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule